// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a small table of interrupt vectors, each with a message address, a message data word and a per-vector mask. It also keeps a Pending Bit Array (PBA) with one bit per vector, and it decides when each vector's memory-write interrupt message goes out. Device logic raises per-vector trigger pulses. A single message port presents the address and data of each interrupt message under a valid/ready handshake. A simple register port gives software aligned dword and qword access to the table and the PBA. A level input carries the function-wide mask.

Every event is first recorded as a pending bit. A dispatcher takes the lowest-numbered vector that is pending and not masked, moves it into the output register and clears its bit in the same clock edge. Unmasking a vector, or clearing the function mask, therefore delivers whatever was held back, with no separate scan step. A vector whose 64-bit message address is zero is dispatched and cleared without producing a message.

The register port selects the table or the PBA with `reg_pba`. Within the table, each vector takes 16 bytes. Within the PBA, each word is 64 bits wide. Reads return data one cycle after the request.

Top module: `msixc_top`

## Requirements
- R1: After reset every table entry has address 0, data 0 and its mask bit set, every pending bit is 0, and no message or read response is presented.
- R2: A table entry takes 16 bytes at byte offset 16*v. As dwords, offset 0 holds the address low half, offset 4 the address high half, offset 8 the data and offset 12 the control word. Bit 0 of the control word is the vector mask, and the other control bits read 0. A qword at offset 0 is {address high, address low}, and a qword at offset 8 is {control, data}, with the low half in bits 31:0. A dword read returns its value in bits 31:0 with bits 63:32 zero.
- R3: A trigger on a vector whose own mask or the function mask is set sets that vector's pending bit and produces no message for as long as the vector stays masked.
- R4: A trigger on an unmasked vector sets its pending bit at the next edge. If the output is free, the message is valid after the following edge and the bit reads 0 again.
- R5: Writing a pending vector's mask bit to 0 while the function mask is clear delivers its message and clears its pending bit.
- R6: When the function mask goes from 1 to 0, every pending, unmasked vector is delivered and cleared, one per accepted message, lowest vector index first.
- R7: A vector whose 64-bit message address is zero never produces a message; its pending bit is cleared at the point where it would have been delivered.
- R8: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data hold. Triggers arriving meanwhile stay pending and are delivered later, so none is lost.
- R9: The PBA holds vector v in word v/64 at bit v%64. A qword at word offset 0 returns the whole word, a dword at offset 0 returns bits 31:0, and a dword at offset 4 returns bits 63:32. Writes to the PBA change nothing.
- R10: A dword access whose byte offset is not a multiple of 4, a qword table access not at entry offset 0 or 8, and a PBA qword access not at word offset 0 all read as 0 and are ignored on write.
- R11: A table access to an entry index of NUM_VEC or above, or a PBA access to a word beyond the last one, reads as 0 and is ignored on write.
- R12: Every read request gives reg_rvalid = 1 with its data exactly one cycle later. reg_rvalid is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_pba | input | 1 | 1 = PBA region, 0 = vector table region |
| reg_qword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | ADDR_W | Byte offset within the selected region |
| reg_wdata | input | 64 | Write data (dword uses bits 31:0) |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| reg_rdata | output | 64 | Read data |
| func_mask | input | 1 | Function-wide mask level |
| trig | input | NUM_VEC | Per-vector trigger pulses |
| msg_valid | output | 1 | Interrupt message present |
| msg_ready | input | 1 | Message accepted when high together with msg_valid |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions assume that reset is held for at least one edge before any other activity and that no register request is made while reset is high. They also assume that msg_ready is an ordinary level that may drop in any cycle, including while a message is waiting. The stimulus applies reset from time zero and keeps reg_valid low during it. It changes every input only on falling clock edges, so each property sees stable inputs at the sampling edge. Random phases toggle msg_ready and func_mask freely and respect no special pattern, which exercises the hold and no-loss properties under stall.

// File: rtl/msixc_pkg.sv
package msixc_pkg;

    localparam int unsigned PBA_WORD_BITS = 64;

    typedef struct packed {
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

    localparam vec_entry_t ENTRY_RESET = '{addr_hi: '0, addr_lo: '0, data: '0, mask: 1'b1};

    // table access legality from access width and offset inside the 16-byte entry
    function automatic logic tbl_access_ok(input logic qword, input logic [3:0] off);
        if (qword) return (off == 4'h0) || (off == 4'h8);
        return off[1:0] == 2'b00;
    endfunction

    // PBA access legality from access width and offset inside the 8-byte word
    function automatic logic pba_access_ok(input logic qword, input logic [2:0] off);
        if (qword) return off == 3'd0;
        return off[1:0] == 2'b00;
    endfunction

    function automatic logic [63:0] entry_addr(input vec_entry_t e);
        return {e.addr_hi, e.addr_lo};
    endfunction

endpackage

// File: rtl/msixc_table.sv
module msixc_table
    import msixc_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     qword,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [63:0]              wdata,
    output logic [63:0]              rd_val,
    output vec_entry_t [NUM_VEC-1:0] entries
);
    localparam int ENT_W = ADDR_W - 4;

    logic [ENT_W-1:0] ent;
    logic [3:0]       off;
    logic             hit;
    logic             legal;
    vec_entry_t       sel;

    assign ent   = addr[ADDR_W-1:4];
    assign off   = addr[3:0];
    assign hit   = ent < ENT_W'(NUM_VEC);
    assign legal = hit && tbl_access_ok(qword, off);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[v] <= ENTRY_RESET;
            end else if (wr_en && legal && (ent == ENT_W'(v))) begin
                if (qword) begin
                    if (off == 4'h0) begin
                        entries[v].addr_lo <= wdata[31:0];
                        entries[v].addr_hi <= wdata[63:32];
                    end else begin
                        entries[v].data <= wdata[31:0];
                        entries[v].mask <= wdata[32];
                    end
                end else begin
                    case (off[3:2])
                        2'd0:    entries[v].addr_lo <= wdata[31:0];
                        2'd1:    entries[v].addr_hi <= wdata[31:0];
                        2'd2:    entries[v].data    <= wdata[31:0];
                        default: entries[v].mask    <= wdata[0];
                    endcase
                end
            end
        end
    end

    always_comb begin
        sel = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (ent == ENT_W'(v)) sel = entries[v];
        end
    end

    always_comb begin
        rd_val = '0;
        if (legal) begin
            if (qword) begin
                rd_val = (off == 4'h0) ? {sel.addr_hi, sel.addr_lo}
                                       : {31'b0, sel.mask, sel.data};
            end else begin
                case (off[3:2])
                    2'd0:    rd_val = {32'b0, sel.addr_lo};
                    2'd1:    rd_val = {32'b0, sel.addr_hi};
                    2'd2:    rd_val = {32'b0, sel.data};
                    default: rd_val = {63'b0, sel.mask};
                endcase
            end
        end
    end
endmodule

// File: rtl/msixc_pba.sv
module msixc_pba
    import msixc_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] trig,
    input  logic [NUM_VEC-1:0] clr,
    input  logic               qword,
    input  logic [ADDR_W-1:0]  addr,
    output logic [63:0]        rd_val,
    output logic [NUM_VEC-1:0] pend
);
    localparam int PBA_WORDS = (NUM_VEC + PBA_WORD_BITS - 1) / PBA_WORD_BITS;
    localparam int WORD_W    = ADDR_W - 3;

    logic [PBA_WORDS*PBA_WORD_BITS-1:0] padded;
    logic [WORD_W-1:0]                  word_idx;
    logic [2:0]                         off;
    logic [63:0]                        word;
    logic                               legal;

    // a new trigger wins over a dispatch clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | trig;
    end

    assign word_idx = addr[ADDR_W-1:3];
    assign off      = addr[2:0];
    assign legal    = (word_idx < WORD_W'(PBA_WORDS)) && pba_access_ok(qword, off);

    always_comb begin
        padded = '0;
        padded[NUM_VEC-1:0] = pend;
    end

    always_comb begin
        word = '0;
        for (int w = 0; w < PBA_WORDS; w++) begin
            if (word_idx == WORD_W'(w)) word = padded[w*PBA_WORD_BITS +: PBA_WORD_BITS];
        end
    end

    always_comb begin
        rd_val = '0;
        if (legal) begin
            if (qword)         rd_val = word;
            else if (off[2])   rd_val = {32'b0, word[63:32]};
            else               rd_val = {32'b0, word[31:0]};
        end
    end
endmodule

// File: rtl/msixc_dispatch.sv
module msixc_dispatch
    import msixc_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_VEC-1:0]       pend,
    input  vec_entry_t [NUM_VEC-1:0] entries,
    input  logic                     func_mask,
    input  logic                     msg_ready,
    output logic [NUM_VEC-1:0]       clr,
    output logic                     msg_valid,
    output logic [63:0]              msg_addr,
    output logic [31:0]              msg_data
);
    logic [NUM_VEC-1:0] eligible;
    logic [NUM_VEC-1:0] pick_oh;
    vec_entry_t         pick_e;
    logic               slot_free;
    logic               any;

    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            eligible[v] = pend[v] && !entries[v].mask && !func_mask;
        end
    end

    // lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        pick_oh = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (eligible[v]) begin
                pick_oh    = '0;
                pick_oh[v] = 1'b1;
            end
        end
    end

    always_comb begin
        pick_e = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (pick_oh[v]) pick_e = entries[v];
        end
    end

    assign any       = |eligible;
    assign slot_free = !msg_valid || msg_ready;
    assign clr       = slot_free ? pick_oh : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (slot_free) begin
            msg_valid <= any && (entry_addr(pick_e) != 64'd0);
            if (any) begin
                msg_addr <= entry_addr(pick_e);
                msg_data <= pick_e.data;
            end
        end
    end
endmodule

// File: rtl/msixc_top.sv
module msixc_top
    import msixc_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic               reg_pba,
    input  logic               reg_qword,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic               reg_rvalid,
    output logic [63:0]        reg_rdata,
    input  logic               func_mask,
    input  logic [NUM_VEC-1:0] trig,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    vec_entry_t [NUM_VEC-1:0] entries;
    logic [NUM_VEC-1:0]       pend_q;
    logic [NUM_VEC-1:0]       clr;
    logic [NUM_VEC-1:0]       vmask;
    logic [63:0]              tbl_val;
    logic [63:0]              pba_val;
    logic                     tbl_wr;
    logic                     rd_req;

    assign tbl_wr = reg_valid && reg_write && !reg_pba;
    assign rd_req = reg_valid && !reg_write;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_mask
        assign vmask[v] = entries[v].mask;
    end

    msixc_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst(rst), .wr_en(tbl_wr), .qword(reg_qword), .addr(reg_addr),
        .wdata(reg_wdata), .rd_val(tbl_val), .entries(entries)
    );

    msixc_pba #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_pba (
        .clk(clk), .rst(rst), .trig(trig), .clr(clr), .qword(reg_qword),
        .addr(reg_addr), .rd_val(pba_val), .pend(pend_q)
    );

    msixc_dispatch #(.NUM_VEC(NUM_VEC)) u_disp (
        .clk(clk), .rst(rst), .pend(pend_q), .entries(entries), .func_mask(func_mask),
        .msg_ready(msg_ready), .clr(clr), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= rd_req;
            if (rd_req) reg_rdata <= reg_pba ? pba_val : tbl_val;
        end
    end
endmodule

// File: rtl/msixc_checker.sv
module msixc_checker #(
    parameter int NUM_VEC = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_valid,
    input logic               reg_write,
    input logic               reg_rvalid,
    input logic               func_mask,
    input logic [NUM_VEC-1:0] trig,
    input logic [NUM_VEC-1:0] pend,
    input logic [NUM_VEC-1:0] vmask,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!msg_valid && !reg_rvalid && (pend == '0)));

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    a_r7_no_zero_addr: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr != 64'd0));

    a_r12_read_answers: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_write) |=> reg_rvalid);

    a_r12_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
        reg_rvalid |-> $past(reg_valid && !reg_write));

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        a_r8_trigger_recorded: assert property (@(posedge clk) disable iff (rst)
            trig[v] |=> pend[v]);

        a_r3_masked_stays_pending: assert property (@(posedge clk) disable iff (rst)
            (pend[v] && (vmask[v] || func_mask)) |=> pend[v]);
    end
endmodule

bind msixc_top msixc_checker #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_rvalid(reg_rvalid), .func_mask(func_mask), .trig(trig), .pend(pend_q),
    .vmask(vmask), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msixc_top_bench.sv
`timescale 1ns/1ps
module msixc_top_bench;
    localparam int NV = 8;
    localparam int AW = 12;
    localparam logic [31:0] HI = 32'h0000_000A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_valid = 0, reg_write = 0, reg_pba = 0, reg_qword = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [63:0]   reg_wdata = '0;
    logic          reg_rvalid;
    logic [63:0]   reg_rdata;
    logic          func_mask = 0;
    logic [NV-1:0] trig = '0;
    logic          msg_valid;
    logic          msg_ready = 0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    always #2 clk = ~clk;

    msixc_top #(.NUM_VEC(NV), .ADDR_W(AW)) u_msixc_top (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_pba(reg_pba), .reg_qword(reg_qword), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .func_mask(func_mask), .trig(trig), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_addr [NV];
    logic [31:0] m_data [NV];
    bit          m_mask [NV];
    bit          m_pend [NV];
    bit          m_ov, m_rv;
    logic [63:0] m_oa, m_rd;
    logic [31:0] m_od;
    logic [63:0] acc_q [$];

    function automatic logic [63:0] mread(bit pba, bit qw, int unsigned a);
        int unsigned e, o;
        logic [63:0] w;
        if (pba) begin
            e = a / 8; o = a % 8;
            if (e != 0) return 64'd0;
            w = '0;
            for (int v = 0; v < NV; v++) w[v] = m_pend[v];
            if (qw) return (o == 0) ? w : 64'd0;
            if (o == 0) return {32'd0, w[31:0]};
            if (o == 4) return {32'd0, w[63:32]};
            return 64'd0;
        end
        e = a / 16; o = a % 16;
        if (e >= NV) return 64'd0;
        if (qw) begin
            if (o == 0) return m_addr[e];
            if (o == 8) return {31'd0, m_mask[e], m_data[e]};
            return 64'd0;
        end
        case (o)
            0:  return {32'd0, m_addr[e][31:0]};
            4:  return {32'd0, m_addr[e][63:32]};
            8:  return {32'd0, m_data[e]};
            12: return {63'd0, m_mask[e]};
            default: return 64'd0;
        endcase
    endfunction

    task automatic mwrite(bit qw, int unsigned a, logic [63:0] d);
        int unsigned e, o;
        e = a / 16; o = a % 16;
        if (e >= NV) return;
        if (qw) begin
            if (o == 0) m_addr[e] = d;
            else if (o == 8) begin m_data[e] = d[31:0]; m_mask[e] = d[32]; end
        end else begin
            case (o)
                0:  m_addr[e][31:0]  = d[31:0];
                4:  m_addr[e][63:32] = d[31:0];
                8:  m_data[e]        = d[31:0];
                12: m_mask[e]        = d[0];
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin : model
        bit free;
        int pick;
        if (rst) begin
            for (int v = 0; v < NV; v++) begin
                m_addr[v] = '0; m_data[v] = '0; m_mask[v] = 1; m_pend[v] = 0;
            end
            m_ov = 0; m_rv = 0; m_oa = '0; m_od = '0; m_rd = '0;
        end else begin
            if (msg_valid && msg_ready) acc_q.push_back(msg_addr);
            m_rv = reg_valid && !reg_write;
            if (m_rv) m_rd = mread(reg_pba, reg_qword, reg_addr);
            free = !m_ov || msg_ready;
            pick = -1;
            if (free && !func_mask)
                for (int v = NV - 1; v >= 0; v--) if (m_pend[v] && !m_mask[v]) pick = v;
            if (free) begin
                if (pick >= 0) begin
                    m_ov = (m_addr[pick] != 0);
                    m_oa = m_addr[pick];
                    m_od = m_data[pick];
                    m_pend[pick] = 0;
                end else m_ov = 0;
            end
            for (int v = 0; v < NV; v++) if (trig[v]) m_pend[v] = 1;
            if (reg_valid && reg_write && !reg_pba) mwrite(reg_qword, reg_addr, reg_wdata);
        end
    end

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    // compare design against model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "msg_valid", 64'(msg_valid), 64'(m_ov));
            if (m_ov) begin
                check(cur_req, "msg_addr", msg_addr, m_oa);
                check(cur_req, "msg_data", 64'(msg_data), 64'(m_od));
            end
            check("R12", "reg_rvalid", 64'(reg_rvalid), 64'(m_rv));
            if (m_rv) check(cur_req, "reg_rdata", reg_rdata, m_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog expired got %0d exp %0d", cycles, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(bit pba, bit qw, int unsigned a, logic [63:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_pba = pba; reg_qword = qw;
        reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd(string req, bit pba, bit qw, int unsigned a, logic [63:0] exp);
        @(negedge clk);
        reg_valid = 1; reg_write = 0; reg_pba = pba; reg_qword = qw; reg_addr = AW'(a);
        @(negedge clk);
        reg_valid = 0;
        check(req, "read value", reg_rdata, exp);
    endtask

    task automatic pulse(logic [NV-1:0] t);
        @(negedge clk); trig = t;
        @(negedge clk); trig = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] vaddr(int v);
        return {HI, 32'h1000 + 32'(v * 16)};
    endfunction

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 0;

        cur_req = "R1";
        rd("R1", 0, 0, 16'h3C, 64'd1);
        rd("R1", 0, 1, 16'h20, 64'd0);
        rd("R1", 1, 1, 0, 64'd0);

        cur_req = "R2";
        for (int v = 0; v < NV; v++) begin
            if (v != 5) begin
                wr(0, 0, v * 16, {32'd0, vaddr(v)[31:0]});
                wr(0, 0, v * 16 + 4, {32'd0, HI});
            end
            wr(0, 1, v * 16 + 8, {32'd1, 32'hD000 + 32'(v)});
        end
        rd("R2", 0, 1, 16'h40, vaddr(4));
        rd("R2", 0, 1, 16'h48, {32'd1, 32'hD004});
        rd("R2", 0, 0, 16'h48, 64'h0000_0000_0000_D004);
        rd("R2", 0, 0, 16'h44, {32'd0, HI});
        wr(0, 0, 16'h6C, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R2", 0, 0, 16'h6C, 64'd1);

        cur_req = "R3";
        pulse(8'b0000_0110);
        idle(3);
        rd("R3", 1, 0, 0, 64'h6);
        check("R3", "messages while masked", 64'(acc_q.size()), 64'd0);

        cur_req = "R5";
        msg_ready = 1;
        wr(0, 0, 16'h2C, 64'd0);
        idle(4);
        check("R5", "message count", 64'(acc_q.size()), 64'd1);
        if (acc_q.size() > 0) check("R5", "message address", acc_q[0], vaddr(2));
        rd("R5", 1, 0, 0, 64'h2);

        cur_req = "R6";
        func_mask = 1;
        wr(0, 0, 16'h1C, 64'd0);
        wr(0, 0, 16'h3C, 64'd0);
        wr(0, 0, 16'h0C, 64'd0);
        pulse(8'b0000_1001);
        idle(3);
        rd("R6", 1, 0, 0, 64'hB);
        check("R6", "held by function mask", 64'(acc_q.size()), 64'd1);
        @(negedge clk); func_mask = 0;
        idle(6);
        check("R6", "message count", 64'(acc_q.size()), 64'd4);
        if (acc_q.size() >= 4) begin
            check("R6", "first after unmask", acc_q[1], vaddr(0));
            check("R6", "second after unmask", acc_q[2], vaddr(1));
            check("R6", "third after unmask", acc_q[3], vaddr(3));
        end
        rd("R6", 1, 1, 0, 64'd0);

        cur_req = "R4";
        pulse(8'b0000_1000);
        idle(3);
        check("R4", "message count", 64'(acc_q.size()), 64'd5);
        if (acc_q.size() >= 5) check("R4", "message address", acc_q[4], vaddr(3));
        rd("R4", 1, 0, 0, 64'd0);

        cur_req = "R7";
        wr(0, 0, 16'h5C, 64'd0);
        pulse(8'b0010_0000);
        idle(4);
        check("R7", "no message for zero address", 64'(acc_q.size()), 64'd5);
        rd("R7", 1, 0, 0, 64'd0);

        cur_req = "R8";
        @(negedge clk); msg_ready = 0;
        pulse(8'b0000_0001);
        idle(1);
        pulse(8'b0000_1010);
        idle(3);
        check("R8", "valid while stalled", 64'(msg_valid), 64'd1);
        check("R8", "stalled address", msg_addr, vaddr(0));
        rd("R8", 1, 0, 0, 64'hA);
        base = acc_q.size();
        @(negedge clk); msg_ready = 1;
        idle(8);
        check("R8", "delivered after stall", 64'(acc_q.size()), 64'(base + 3));
        if (acc_q.size() >= base + 3) begin
            check("R8", "order 0", acc_q[base], vaddr(0));
            check("R8", "order 1", acc_q[base + 1], vaddr(1));
            check("R8", "order 2", acc_q[base + 2], vaddr(3));
        end

        cur_req = "R9";
        pulse(8'b0100_0000);
        idle(2);
        wr(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(1, 0, 4, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R9", 1, 1, 0, 64'h40);
        rd("R9", 1, 0, 0, 64'h40);
        rd("R9", 1, 0, 4, 64'd0);

        cur_req = "R10";
        wr(0, 0, 16'h12, 64'h0);
        rd("R10", 0, 0, 16'h12, 64'd0);
        rd("R10", 0, 0, 16'h10, 64'h1010);
        rd("R10", 0, 1, 16'h14, 64'd0);
        wr(0, 1, 16'h04, 64'h0);
        rd("R10", 0, 0, 16'h00, 64'h1000);
        rd("R10", 1, 0, 16'h02, 64'd0);
        rd("R10", 1, 1, 16'h04, 64'd0);

        cur_req = "R11";
        rd("R11", 0, 0, 16'h90, 64'd0);
        wr(0, 0, 16'h90, 64'hDEAD);
        wr(0, 0, 16'h9C, 64'h0);
        rd("R11", 0, 0, 16'h10, 64'h1010);
        rd("R11", 0, 0, 16'h1C, 64'd0);
        rd("R11", 0, 1, 16'h80, 64'd0);
        rd("R11", 1, 1, 16'h08, 64'd0);

        cur_req = "R8";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            trig      = NV'($urandom) & NV'($urandom) & NV'($urandom);
            msg_ready = ($urandom % 4) != 0;
            if (($urandom % 50) == 0) func_mask = ~func_mask;
            reg_valid = 0; reg_write = 0;
            if (($urandom % 10) == 0) begin
                reg_valid = 1;
                reg_write = $urandom % 2;
                reg_pba   = ($urandom % 4) == 0;
                reg_qword = $urandom % 2;
                reg_addr  = AW'(($urandom % 10) * 16 + ($urandom % 4) * 4);
                reg_wdata = {$urandom, $urandom};
            end
        end
        @(negedge clk);
        trig = '0; reg_valid = 0; msg_ready = 1; func_mask = 0;
        idle(30);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule